// File: doc/BRIEF.md
# Lockable Configuration Register with Power-On Channel Recall

This block keeps the 8-bit configuration word of a four-channel converter and fills the four channel working registers after reset. At reset the stored configuration image is taken from the nonvolatile store on `cfg_boot`. The block then walks the channels in ascending order, one per clock. It hands each channel a value chosen by the power-on mode field: zero, full scale, mid scale, or that channel's own stored word. Only after the last channel is loaded does it raise `init_done`, and only then will it serve configuration requests from the serial front end.

The configuration word has four fields. Bits 7:4 are the device type that the front end matches for channel addressing. Bit 3 selects the power-down output style. Bits 2:1 are the power-on mode. Bit 0 is a lock. While the lock is clear, the front end may read the word or replace it. Each accepted write raises a one-cycle store request for the nonvolatile copy. Once the lock is set, every bus access is refused, and only the factory clear input can reopen the register.

Top module: `cfg_recall`

## Requirements
- R1: While `rst_n` is low the register takes `cfg_boot`, `init_done` is 0, and `cfg_ack`, `cfg_nack`, `cfg_store` and `cfg_rd_data` are 0.
- R2: After reset is released, `ld_en` is high for exactly CH consecutive cycles. During those cycles `ld_ch` runs 0, 1, 2, 3 in order. `init_done` then rises and stays high, and `ld_en` stays low.
- R3: The loaded value follows configuration bits 2:1. The code 00 gives 0, 01 gives all ones (3FFh), and 10 gives mid scale (200h). The code 11 gives `nv_rd_data`, which is read for the channel shown on `nv_rd_addr` (equal to `ld_ch`).
- R4: A read or write request made before `init_done` is refused. `cfg_nack` pulses in the next cycle and the register is unchanged.
- R5: With bit 0 clear, a write whose bits 7:4 are not 1001b is accepted. The register holds the written byte from the next cycle, and `cfg_ack` and `cfg_store` pulse for one cycle.
- R6: With bit 0 clear, a read is accepted. `cfg_rd_data` holds the register value and `cfg_ack` pulses in the next cycle.
- R7: With bit 0 set, reads and writes are refused with `cfg_nack`. The register and `cfg_rd_data` are unchanged.
- R8: A write carrying 1001b in bits 7:4 is refused with `cfg_nack` and leaves the register unchanged.
- R9: A `factory_clr` pulse clears bit 0 in the next cycle and keeps the other bits. A write in the same cycle is judged against the lock state before the clear. If that write is accepted, it lands with bit 0 forced to 0.
- R10: `dac_type` always equals register bits 7:4, `pd_hiz` equals bit 3, and `cfg_image` equals the whole register.
- R11: When a write and a read are requested in the same cycle, only the write is processed. The read gets no response and `cfg_rd_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| cfg_boot | input | 8 | Stored configuration image, loaded during reset |
| factory_clr | input | 1 | Factory-mode pulse that clears the lock bit |
| cfg_wr_en | input | 1 | Write request from the serial front end |
| cfg_wr_data | input | 8 | Byte to write |
| cfg_rd_en | input | 1 | Read request from the serial front end |
| cfg_rd_data | output | 8 | Value captured by the last accepted read |
| cfg_ack | output | 1 | Request accepted (one cycle after the request) |
| cfg_nack | output | 1 | Request refused (one cycle after the request) |
| cfg_store | output | 1 | Request to store `cfg_image` in nonvolatile memory |
| cfg_image | output | 8 | Current configuration register |
| dac_type | output | 4 | Device type used for channel addressing |
| pd_hiz | output | 1 | Power-down output style: 1 high impedance, 0 low impedance |
| nv_rd_addr | output | CW | Channel whose stored word is requested |
| nv_rd_data | input | DW | Stored word of that channel |
| ld_en | output | 1 | Load strobe to the channel register bank |
| ld_ch | output | CW | Channel being loaded |
| ld_val | output | DW | Value to load |
| init_done | output | 1 | All channels loaded; bus access enabled |

## Verification
A factory clear can arrive in the same cycle as a bus write. The outcome then depends on which lock state the write is judged against. The bench issues both together in two cases: with the register locked, and with it unlocked while the written byte sets the lock. It expects a refusal with bit 0 cleared in the first case, and acceptance with bit 0 still cleared in the second. A simultaneous read and write is provoked as well. For that case the bench checks that only the write takes effect and that the read data does not change.

// File: rtl/cfg_recall.sv
module cfg_recall #(
  parameter int CH = 4,
  parameter int DW = 10,
  parameter int CW = (CH > 1) ? $clog2(CH) : 1,
  parameter logic [3:0] SELF_TYPE = 4'b1001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_boot,
  input  logic          factory_clr,
  input  logic          cfg_wr_en,
  input  logic [7:0]    cfg_wr_data,
  input  logic          cfg_rd_en,
  output logic [7:0]    cfg_rd_data,
  output logic          cfg_ack,
  output logic          cfg_nack,
  output logic          cfg_store,
  output logic [7:0]    cfg_image,
  output logic [3:0]    dac_type,
  output logic          pd_hiz,
  output logic [CW-1:0] nv_rd_addr,
  input  logic [DW-1:0] nv_rd_data,
  output logic          ld_en,
  output logic [CW-1:0] ld_ch,
  output logic [DW-1:0] ld_val,
  output logic          init_done
);
  logic [7:0]    cfg;
  logic [CW-1:0] cnt;
  logic          done;
  logic          pv;

  wire open_q = done && !cfg[0];
  wire wr_ok  = cfg_wr_en && open_q && (cfg_wr_data[7:4] != SELF_TYPE);
  wire wr_bad = cfg_wr_en && !wr_ok;
  wire rd_ok  = cfg_rd_en && !cfg_wr_en && open_q;
  wire rd_bad = cfg_rd_en && !cfg_wr_en && !open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg         <= cfg_boot;
      cnt         <= '0;
      done        <= 1'b0;
      cfg_ack     <= 1'b0;
      cfg_nack    <= 1'b0;
      cfg_store   <= 1'b0;
      cfg_rd_data <= '0;
      pv          <= 1'b0;
    end else begin
      pv <= 1'b1;
      if (!done) begin
        if (cnt == CW'(CH - 1)) done <= 1'b1;
        else cnt <= cnt + 1'b1;
      end
      cfg_ack   <= wr_ok | rd_ok;
      cfg_nack  <= wr_bad | rd_bad;
      cfg_store <= wr_ok;
      if (wr_ok) cfg <= {cfg_wr_data[7:1], cfg_wr_data[0] & ~factory_clr};
      else if (factory_clr) cfg[0] <= 1'b0;
      if (rd_ok) cfg_rd_data <= cfg;
    end
  end

  always_comb begin
    case (cfg[2:1])
      2'b00:   ld_val = '0;
      2'b01:   ld_val = '1;
      2'b10:   ld_val = {1'b1, {(DW-1){1'b0}}};
      default: ld_val = nv_rd_data;
    endcase
  end

  assign ld_en      = !done;
  assign ld_ch      = cnt;
  assign nv_rd_addr = cnt;
  assign init_done  = done;
  assign cfg_image  = cfg;
  assign dac_type   = cfg[7:4];
  assign pd_hiz     = cfg[3];

  p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(init_done)) |-> init_done);
  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && ld_en && $past(ld_en)) |-> (ld_ch == CW'($past(ld_ch) + 1'b1)));
  p_ack_after_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ack |-> init_done);
  p_store_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_store |-> (cfg_ack && !cfg_nack));
  p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(cfg_image[0]) && !$past(factory_clr)) |-> $stable(cfg_image));
  p_no_self_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(dac_type) != SELF_TYPE) |-> (dac_type != SELF_TYPE));
  p_clear_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(factory_clr)) |-> !cfg_image[0]);
endmodule

// File: tb/tb_cfg_recall.sv
module tb_cfg_recall;
  localparam int CH = 4;
  localparam int DW = 10;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_boot = 8'h5F;
  logic factory_clr = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic cfg_rd_en = 1'b0;
  logic [7:0] cfg_rd_data;
  logic cfg_ack, cfg_nack, cfg_store;
  logic [7:0] cfg_image;
  logic [3:0] dac_type;
  logic pd_hiz;
  logic [CW-1:0] nv_rd_addr;
  logic [DW-1:0] nv_rd_data;
  logic ld_en;
  logic [CW-1:0] ld_ch;
  logic [DW-1:0] ld_val;
  logic init_done;
  int seed = 0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] nvf(int a, int s);
    return DW'((a * 293 + s * 71 + 5) % 1024);
  endfunction

  assign nv_rd_data = nvf(int'(nv_rd_addr), seed);

  cfg_recall #(.CH(CH), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_boot(cfg_boot), .factory_clr(factory_clr),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_en(cfg_rd_en),
    .cfg_rd_data(cfg_rd_data), .cfg_ack(cfg_ack), .cfg_nack(cfg_nack),
    .cfg_store(cfg_store), .cfg_image(cfg_image), .dac_type(dac_type),
    .pd_hiz(pd_hiz), .nv_rd_addr(nv_rd_addr), .nv_rd_data(nv_rd_data),
    .ld_en(ld_en), .ld_ch(ld_ch), .ld_val(ld_val), .init_done(init_done));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [7:0] boot);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_boot = boot;
    @(negedge clk);
    chk("R1 image", int'(cfg_image), int'(boot));
    chk("R1 done", int'(init_done), 0);
    chk("R1 resp", int'({cfg_ack, cfg_nack, cfg_store}), 0);
    chk("R1 rd_data", int'(cfg_rd_data), 0);
    chk("R10 type", int'(dac_type), int'(boot[7:4]));
    chk("R10 hiz", int'(pd_hiz), int'(boot[3]));
    rst_n = 1'b1;
    #0.5;
  endtask

  task automatic run_recall(logic [7:0] boot);
    do_reset(boot);
    for (int k = 0; k < CH; k++) begin
      int e;
      case (boot[2:1])
        2'b00: e = 0;
        2'b01: e = 1023;
        2'b10: e = 512;
        default: e = int'(nvf(k, seed));
      endcase
      chk("R2 ld_en", int'(ld_en), 1);
      chk("R2 ld_ch", int'(ld_ch), k);
      chk("R2 done low", int'(init_done), 0);
      chk("R3 ld_val", int'(ld_val), e);
      chk("R3 nv_addr", int'(nv_rd_addr), k);
      @(negedge clk);
      #0.5;
    end
    chk("R2 done", int'(init_done), 1);
    chk("R2 ld_en off", int'(ld_en), 0);
    @(negedge clk);
    chk("R2 done held", int'(init_done), 1);
    chk("R2 ld_en held", int'(ld_en), 0);
  endtask

  task automatic req(logic wr, logic [7:0] d, logic rd, logic fc);
    @(negedge clk);
    cfg_wr_en = wr;
    cfg_wr_data = d;
    cfg_rd_en = rd;
    factory_clr = fc;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    cfg_rd_en = 1'b0;
    factory_clr = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 256; b++) begin
      seed = b;
      run_recall(8'(b));
    end

    do_reset(8'h5E);
    req(1'b1, 8'h3A, 1'b0, 1'b0);
    chk("R4 nack early", int'(cfg_nack), 1);
    chk("R4 ack early", int'(cfg_ack), 0);
    chk("R4 image", int'(cfg_image), 8'h5E);
    repeat (4) @(negedge clk);

    req(1'b1, 8'h3A, 1'b0, 1'b0);
    chk("R5 ack", int'(cfg_ack), 1);
    chk("R5 store", int'(cfg_store), 1);
    chk("R5 image", int'(cfg_image), 8'h3A);
    chk("R10 type", int'(dac_type), 3);
    chk("R10 hiz", int'(pd_hiz), 1);
    @(negedge clk);
    chk("R5 pulse", int'({cfg_ack, cfg_store}), 0);

    req(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 ack", int'(cfg_ack), 1);
    chk("R6 store", int'(cfg_store), 0);
    chk("R6 rd_data", int'(cfg_rd_data), 8'h3A);

    begin
      logic [7:0] cur;
      cur = 8'h3A;
      for (int v = 0; v < 256; v += 2) begin
        logic okw;
        okw = (v[7:4] != 4'b1001);
        req(1'b1, 8'(v), 1'b0, 1'b0);
        if (okw) cur = 8'(v);
        chk(okw ? "R5 sweep ack" : "R8 sweep nack", int'({cfg_ack, cfg_nack}), okw ? 2 : 1);
        chk(okw ? "R5 sweep image" : "R8 sweep image", int'(cfg_image), int'(cur));
        chk("R10 sweep type", int'(dac_type), int'(cur[7:4]));
        chk("R10 sweep hiz", int'(pd_hiz), int'(cur[3]));
      end
    end

    req(1'b1, 8'h64, 1'b0, 1'b0);
    req(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 rd_data", int'(cfg_rd_data), 8'h64);
    req(1'b1, 8'h92, 1'b0, 1'b0);
    chk("R8 nack", int'(cfg_nack), 1);
    chk("R8 image", int'(cfg_image), 8'h64);

    req(1'b1, 8'h72, 1'b1, 1'b0);
    chk("R11 ack", int'({cfg_ack, cfg_nack}), 2);
    chk("R11 image", int'(cfg_image), 8'h72);
    chk("R11 rd_data", int'(cfg_rd_data), 8'h64);

    req(1'b1, 8'h71, 1'b0, 1'b0);
    chk("R5 lock set", int'(cfg_image), 8'h71);
    req(1'b1, 8'h20, 1'b0, 1'b0);
    chk("R7 wr nack", int'({cfg_ack, cfg_nack}), 1);
    chk("R7 image", int'(cfg_image), 8'h71);
    req(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R7 rd nack", int'({cfg_ack, cfg_nack}), 1);
    chk("R7 rd_data", int'(cfg_rd_data), 8'h64);

    req(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R9 clear", int'(cfg_image), 8'h70);
    chk("R9 no resp", int'({cfg_ack, cfg_nack}), 0);

    req(1'b1, 8'h41, 1'b0, 1'b0);
    chk("R5 relock", int'(cfg_image), 8'h41);
    req(1'b1, 8'h80, 1'b0, 1'b1);
    chk("R9 locked+clr nack", int'({cfg_ack, cfg_nack}), 1);
    chk("R9 locked+clr image", int'(cfg_image), 8'h40);

    req(1'b1, 8'h53, 1'b0, 1'b1);
    chk("R9 open+clr ack", int'({cfg_ack, cfg_nack}), 2);
    chk("R9 open+clr image", int'(cfg_image), 8'h52);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule